// File: doc/BRIEF.md
# Paired Page Descriptor Permission Checker

This block takes a translation entry that has already been found to match a virtual address and decides what the access may do. The entry carries two page descriptors: one for the even page of an adjacent pair and one for the odd page. The block picks one of the two using a single virtual-address bit. It then runs a fixed sequence of permission checks against the access kind and the current privilege level. If every check passes, it produces a physical address and the read, write and execute rights. If a check fails, it produces a fault code.

The decision logic is combinational. The result is captured in one output register stage, qualified by a valid strobe, so every result appears exactly one clock after it is presented. Finding the matching entry and turning a fault code into an exception are left to the surrounding logic.

Top module: `pair_page_check`

## Requirements
- R1: While `rstN` is low, `validOut`, `faultCode`, `physAddr`, `canRead`, `canWrite` and `canExec` are all 0.
- R2: A request sampled with `validIn` high at a rising edge shows its result at that edge's outputs, and `validOut` is high for that one cycle. After an edge where `validIn` is low, `validOut` is low and the other outputs keep their previous values.
- R3: Address bit `vaddr[pageShift]` selects the descriptor: 0 selects `descEven` and 1 selects `descOdd`. Descriptor layout: bit 0 valid, bit 1 dirty, bits 3:2 entry level, bit 4 restrict-level, bit 5 no-execute, bit 6 no-read, bits 42:7 physical page number.
- R4: A selected descriptor with valid clear gives fault code 3, whatever the other fields hold. The codes 1 (bad address) and 2 (no match) belong to the wider code space and are never produced.
- R5: Access kind encoding is 0 fetch, 1 load, 2 store. A fetch from a descriptor with no-execute set gives fault code 6.
- R6: A load from a descriptor with no-read set gives fault code 5.
- R7: When restrict-level is 0, fault code 7 is given if `curLevel` is numerically greater than the entry level. When restrict-level is 1, fault code 7 is given if `curLevel` differs from the entry level.
- R8: A store to a descriptor with dirty clear gives fault code 4.
- R9: If several checks fail, the reported code is that of the first failing check in this order: valid, no-execute, no-read, privilege, dirty.
- R10: On a match (code 0), `physAddr` equals the page number shifted left by 12, ORed with the low `pageShift` bits of `vaddr`, for `pageShift` from 12 to 30.
- R11: On a match, `canRead` is 1, `canWrite` equals the dirty bit, and `canExec` is the inverse of the no-execute bit.
- R12: When the fault code is non-zero, `physAddr`, `canRead`, `canWrite` and `canExec` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Request present this cycle |
| vaddr | input | VA_W (48) | Virtual address of the access |
| pageShift | input | PS_W (5) | Page-size exponent, 12 to 30 |
| accessKind | input | 2 | 0 fetch, 1 load, 2 store |
| curLevel | input | 2 | Current privilege level |
| descEven | input | DESC_W (43) | Descriptor of the even page |
| descOdd | input | DESC_W (43) | Descriptor of the odd page |
| validOut | output | 1 | Result registered this cycle |
| faultCode | output | 3 | 0 match, 3 to 7 fault kinds |
| physAddr | output | PA_W (48) | Translated physical address |
| canRead | output | 1 | Read right granted |
| canWrite | output | 1 | Write right granted |
| canExec | output | 1 | Execute right granted |

## Verification
Every result (fault code, physical address and rights) is due exactly one rising edge after its request. The bench drives a request on a falling edge, lets the next rising edge capture it, and compares all outputs on the following falling edge, before the next request is driven. The sweep covers every flag combination, access kind and privilege level, with each descriptor selected in turn. The hold check leaves `validIn` low for one edge and confirms at the next falling edge that the outputs did not move.

// File: rtl/pgchk_pkg.sv
package pgchk_pkg;

  localparam int PAGE_LSB     = 12;
  localparam int FLAG_W       = 7;
  localparam int BIT_VALID    = 0;
  localparam int BIT_DIRTY    = 1;
  localparam int BIT_LVL_LO   = 2;
  localparam int BIT_RESTRICT = 4;
  localparam int BIT_NOEXEC   = 5;
  localparam int BIT_NOREAD   = 6;
  localparam int PPN_LSB      = FLAG_W;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_t;

  typedef enum logic [2:0] {
    FLT_NONE    = 3'd0,
    FLT_BADADDR = 3'd1,
    FLT_MISS    = 3'd2,
    FLT_INVALID = 3'd3,
    FLT_DIRTY   = 3'd4,
    FLT_NOREAD  = 3'd5,
    FLT_NOEXEC  = 3'd6,
    FLT_PRIV    = 3'd7
  } fault_t;

  typedef struct packed {
    logic   selOdd;
    logic   hit;
    logic   grantWrite;
    logic   grantExec;
    fault_t fault;
  } ctlStrobes_t;

endpackage

// File: rtl/pgchk_ctrl.sv
module pgchk_ctrl
  import pgchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PS_W = 5
) (
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PS_W-1:0]   pageShift,
  input  logic [1:0]        accessKind,
  input  logic [1:0]        curLevel,
  input  logic [FLAG_W-1:0] flagsEven,
  input  logic [FLAG_W-1:0] flagsOdd,
  output ctlStrobes_t       strobes
);

  localparam int IDX_W = $clog2(VA_W);

  logic [IDX_W-1:0]  pickIdx;
  logic              pickOdd;
  logic [FLAG_W-1:0] flags;
  logic [1:0]        entryLevel;
  logic              privBad;
  accKind_t          kind;
  fault_t            code;

  always_comb begin
    pickIdx    = IDX_W'(pageShift);
    pickOdd    = vaddr[pickIdx];
    flags      = pickOdd ? flagsOdd : flagsEven;
    kind       = accKind_t'(accessKind);
    entryLevel = flags[BIT_LVL_LO +: 2];
    privBad    = flags[BIT_RESTRICT] ? (curLevel != entryLevel)
                                     : (curLevel > entryLevel);

    // ordered checks: first failing one wins
    code = FLT_NONE;
    if (!flags[BIT_VALID])
      code = FLT_INVALID;
    else if (kind == ACC_FETCH && flags[BIT_NOEXEC])
      code = FLT_NOEXEC;
    else if (kind == ACC_LOAD && flags[BIT_NOREAD])
      code = FLT_NOREAD;
    else if (privBad)
      code = FLT_PRIV;
    else if (kind == ACC_STORE && !flags[BIT_DIRTY])
      code = FLT_DIRTY;

    strobes.selOdd     = pickOdd;
    strobes.fault      = code;
    strobes.hit        = (code == FLT_NONE);
    strobes.grantWrite = (code == FLT_NONE) && flags[BIT_DIRTY];
    strobes.grantExec  = (code == FLT_NONE) && !flags[BIT_NOEXEC];
  end

endmodule

// File: rtl/pgchk_dpath.sv
module pgchk_dpath
  import pgchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 5,
  localparam int PPN_W = PA_W - PAGE_LSB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PS_W-1:0]   pageShift,
  input  logic [PPN_W-1:0]  ppnEven,
  input  logic [PPN_W-1:0]  ppnOdd,
  input  ctlStrobes_t       strobes,
  output logic              validOut,
  output logic [2:0]        faultCode,
  output logic [PA_W-1:0]   physAddr,
  output logic              canRead,
  output logic              canWrite,
  output logic              canExec
);

  logic [PPN_W-1:0] ppnSel;
  logic [PA_W-1:0]  pageBase;
  logic [PA_W-1:0]  offMask;
  logic [PA_W-1:0]  nextPa;

  always_comb begin
    ppnSel   = strobes.selOdd ? ppnOdd : ppnEven;
    pageBase = {ppnSel, {PAGE_LSB{1'b0}}};
    offMask  = (PA_W'(1) << pageShift) - PA_W'(1);
    nextPa   = pageBase | (PA_W'(vaddr) & offMask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut  <= 1'b0;
      faultCode <= 3'd0;
      physAddr  <= '0;
      canRead   <= 1'b0;
      canWrite  <= 1'b0;
      canExec   <= 1'b0;
    end else begin
      validOut <= validIn;
      if (validIn) begin
        faultCode <= strobes.fault;
        physAddr  <= strobes.hit ? nextPa : '0;
        canRead   <= strobes.hit;
        canWrite  <= strobes.grantWrite;
        canExec   <= strobes.grantExec;
      end
    end
  end

endmodule

// File: rtl/pair_page_check.sv
module pair_page_check
  import pgchk_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 48,
  parameter int PS_W = 5,
  localparam int PPN_W  = PA_W - PAGE_LSB,
  localparam int DESC_W = PPN_LSB + PPN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              validIn,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [PS_W-1:0]   pageShift,
  input  logic [1:0]        accessKind,
  input  logic [1:0]        curLevel,
  input  logic [DESC_W-1:0] descEven,
  input  logic [DESC_W-1:0] descOdd,
  output logic              validOut,
  output logic [2:0]        faultCode,
  output logic [PA_W-1:0]   physAddr,
  output logic              canRead,
  output logic              canWrite,
  output logic              canExec
);

  ctlStrobes_t strobes;

  pgchk_ctrl #(.VA_W(VA_W), .PS_W(PS_W)) u_ctrl (
    .vaddr      (vaddr),
    .pageShift  (pageShift),
    .accessKind (accessKind),
    .curLevel   (curLevel),
    .flagsEven  (descEven[FLAG_W-1:0]),
    .flagsOdd   (descOdd[FLAG_W-1:0]),
    .strobes    (strobes)
  );

  pgchk_dpath #(.VA_W(VA_W), .PA_W(PA_W), .PS_W(PS_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .vaddr     (vaddr),
    .pageShift (pageShift),
    .ppnEven   (descEven[PPN_LSB +: PPN_W]),
    .ppnOdd    (descOdd[PPN_LSB +: PPN_W]),
    .strobes   (strobes),
    .validOut  (validOut),
    .faultCode (faultCode),
    .physAddr  (physAddr),
    .canRead   (canRead),
    .canWrite  (canWrite),
    .canExec   (canExec)
  );

endmodule

// File: rtl/pair_page_check_sva.sv
module pair_page_check_sva #(
  parameter int PA_W = 48
) (
  input logic            clk,
  input logic            rstN,
  input logic            validIn,
  input logic [1:0]      accessKind,
  input logic            validOut,
  input logic [2:0]      faultCode,
  input logic [PA_W-1:0] physAddr,
  input logic            canRead,
  input logic            canWrite,
  input logic            canExec
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);

  assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> (!validOut && $stable(faultCode) && $stable(physAddr)));

  assert_code_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    validOut |-> (faultCode != 3'd1 && faultCode != 3'd2));

  assert_fetch_exec_R5: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && faultCode == 3'd0 && $past(accessKind) == 2'd0) |-> canExec);

  assert_store_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && faultCode == 3'd0 && $past(accessKind) == 2'd2) |-> canWrite);

  assert_read_on_hit_R11: assert property (@(posedge clk) disable iff (!rstN)
    (validOut && faultCode == 3'd0) |-> canRead);

  assert_fault_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    (faultCode != 3'd0) |-> (physAddr == '0 && !canRead && !canWrite && !canExec));

endmodule

bind pair_page_check pair_page_check_sva #(.PA_W(PA_W)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .validIn    (validIn),
  .accessKind (accessKind),
  .validOut   (validOut),
  .faultCode  (faultCode),
  .physAddr   (physAddr),
  .canRead    (canRead),
  .canWrite   (canWrite),
  .canExec    (canExec)
);

// File: tb/pair_page_check_test.sv
module pair_page_check_test;

  localparam int VA_W   = 48;
  localparam int PA_W   = 48;
  localparam int PPN_W  = PA_W - 12;
  localparam int DESC_W = 7 + PPN_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              validIn = 1'b0;
  logic [VA_W-1:0]   vaddr = '0;
  logic [4:0]        pageShift = 5'd12;
  logic [1:0]        accessKind = 2'd0;
  logic [1:0]        curLevel = 2'd0;
  logic [DESC_W-1:0] descEven = '0;
  logic [DESC_W-1:0] descOdd = '0;
  logic              validOut;
  logic [2:0]        faultCode;
  logic [PA_W-1:0]   physAddr;
  logic              canRead, canWrite, canExec;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  pair_page_check uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .vaddr(vaddr),
    .pageShift(pageShift), .accessKind(accessKind), .curLevel(curLevel),
    .descEven(descEven), .descOdd(descOdd), .validOut(validOut),
    .faultCode(faultCode), .physAddr(physAddr), .canRead(canRead),
    .canWrite(canWrite), .canExec(canExec)
  );

  function automatic logic [2:0] modelFault(input logic [1:0] acc,
                                            input logic [1:0] cur,
                                            input logic [6:0] f);
    logic [1:0] lvl;
    lvl = f[3:2];
    if (!f[0]) return 3'd3;
    if (acc == 2'd0 && f[5]) return 3'd6;
    if (acc == 2'd1 && f[6]) return 3'd5;
    if (f[4] ? (cur != lvl) : (cur > lvl)) return 3'd7;
    if (acc == 2'd2 && !f[1]) return 3'd4;
    return 3'd0;
  endfunction

  function automatic string tagFor(input logic [2:0] c);
    case (c)
      3'd3: return "R4";
      3'd6: return "R5";
      3'd5: return "R6";
      3'd7: return "R7";
      3'd4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  // drive at falling edge, capture at rising edge, compare at next falling edge
  task automatic applyVec(input logic [VA_W-1:0] va, input logic [4:0] ps,
                          input logic [1:0] acc, input logic [1:0] cur,
                          input logic [6:0] fSel, input logic [PPN_W-1:0] ppnSel,
                          input logic [6:0] fOther, input logic [PPN_W-1:0] ppnOther);
    logic       odd;
    logic [2:0] expCode;
    logic [PA_W-1:0] expPa;
    logic [PA_W-1:0] mask;
    logic eR, eW, eX;
    odd = va[ps];
    validIn = 1'b1; vaddr = va; pageShift = ps; accessKind = acc; curLevel = cur;
    if (odd) begin
      descOdd = {ppnSel, fSel}; descEven = {ppnOther, fOther};
    end else begin
      descEven = {ppnSel, fSel}; descOdd = {ppnOther, fOther};
    end
    expCode = modelFault(acc, cur, fSel);
    mask    = (PA_W'(1) << ps) - PA_W'(1);
    expPa   = (expCode == 3'd0) ? (({ppnSel, 12'b0}) | (va & mask)) : '0;
    eR = (expCode == 3'd0);
    eW = eR && fSel[1];
    eX = eR && !fSel[5];
    @(posedge clk);
    @(negedge clk);
    nChecks++;
    if (!validOut || faultCode != expCode || canRead != eR || canWrite != eW || canExec != eX) begin
      nFails++;
      $display("FAIL %s (R3/R9 sel=%0d acc=%0d cur=%0d flags=%b) actual v=%0b code=%0d rwx=%0b%0b%0b expected v=1 code=%0d rwx=%0b%0b%0b",
               tagFor(expCode), odd, acc, cur, fSel, validOut, faultCode,
               canRead, canWrite, canExec, expCode, eR, eW, eX);
    end else if (physAddr != expPa) begin
      nFails++;
      $display("FAIL %s actual pa=%h expected pa=%h", (expCode == 3'd0) ? "R10" : "R12",
               physAddr, expPa);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [VA_W-1:0]  va;
    logic [PPN_W-1:0] p0, p1;
    logic [4:0]       ps;
    logic [2:0]       heldCode;
    logic [PA_W-1:0]  heldPa;
    repeat (3) @(negedge clk);
    // R1: reset state
    nChecks++;
    if (validOut || faultCode != 0 || physAddr != 0 || canRead || canWrite || canExec) begin
      nFails++;
      $display("FAIL R1 actual v=%0b code=%0d pa=%h expected all zero", validOut, faultCode, physAddr);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3 R4..R9 R11 R12: every flag pattern, access kind, level, both halves
    ps = 5'd12;
    for (int sel = 0; sel < 2; sel++)
      for (int acc = 0; acc < 3; acc++)
        for (int cur = 0; cur < 4; cur++)
          for (int f = 0; f < 128; f++) begin
            va = {$urandom, $urandom};
            va[ps] = sel[0];
            p0 = {$urandom, $urandom};
            p1 = ~p0;
            applyVec(va, ps, acc[1:0], cur[1:0], f[6:0], p0, ~f[6:0], p1);
            ps = (ps == 5'd30) ? 5'd12 : ps + 5'd1;
          end

    // R10: every page size, offset all ones and all zeros, both halves
    for (int s = 12; s <= 30; s++)
      for (int k = 0; k < 4; k++) begin
        va = k[0] ? '1 : '0;
        va[s] = k[1];
        p0 = {$urandom, $urandom};
        applyVec(va, s[4:0], 2'd2, 2'd0, 7'b0000011, p0, 7'b0000000, ~p0);
      end

    // R2: idle cycle holds outputs and drops validOut
    applyVec(48'h1234_5678_9abc, 5'd14, 2'd1, 2'd1, 7'b0000111, 36'h0_abcd_1234, 7'b0, 36'h0);
    heldCode = faultCode; heldPa = physAddr;
    validIn = 1'b0; descEven = '0; descOdd = '0; vaddr = '1;
    @(posedge clk); @(negedge clk);
    nChecks++;
    if (validOut || faultCode != heldCode || physAddr != heldPa) begin
      nFails++;
      $display("FAIL R2 actual v=%0b code=%0d pa=%h expected v=0 code=%0d pa=%h",
               validOut, faultCode, physAddr, heldCode, heldPa);
    end
    finishRun();
  end

endmodule